// File: doc/BRIEF.md
# Half-Word Write-Masked Control and Status Register

This block holds a 16-bit control register and a read-only status register behind a simple single-cycle register bus. A write to the control register carries its own per-bit write enable: the upper half of the write data says which of the lower sixteen bits may change, and the lower half gives their new values. Software can therefore set or clear a single control bit in one write, with no read-modify-write and no race against another agent touching a different bit.

Four control bits leave the block as level outputs: a configuration enable, a link-training enable, a root-complex mode select and a generation select. The status register reports a two-bit link state that arrives asynchronously from the link logic and is brought into the register clock domain through a two-flop synchronizer. A link-up flag is derived from that synchronized field. Read data is registered and appears in the cycle after the read strobe.

Top module: `hwcsr_top`

## Requirements
- R1: While reset is low at a clock edge, every control bit, every control output, the synchronizer stages and the read data are cleared to 0.
- R2: A write to offset 0x00 treats write data bits 31:16 as a mask and bits 15:0 as values; control bit i takes value bit i only when mask bit i is 1 and otherwise keeps its value. With no write to offset 0x00 the control register holds.
- R3: A write to offset 0x00 whose mask half is all zero leaves every control bit unchanged.
- R4: The outputs follow control bits as levels: bit 0 is the configuration enable, bit 1 the link-training enable, bit 6 the root-complex mode, bit 7 the generation select (0 selects first generation).
- R5: A read of offset 0x00 returns 0 in bits 31:16 and the control bits in 15:0, on the bus in the cycle after the read strobe; without a read strobe the read data holds.
- R6: A read of offset 0x48 returns the synchronized link state in bits 21:20, the link-up flag in bit 0 and 0 elsewhere; a write to offset 0x48 changes nothing.
- R7: Link-up is 1 only when both link state bits are 1 (state 2'b11).
- R8: A change of the asynchronous link state input appears on the link state output after exactly two rising clock edges.
- R9: A read of any other offset returns 0, and a write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data: mask in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Registered read data |
| link_state_async | input | 2 | Link state from another clock domain |
| cfg_enable | output | 1 | Configuration enable level |
| train_enable | output | 1 | Link-training enable level |
| rc_mode | output | 1 | Root-complex mode select |
| gen_select | output | 1 | Generation select, 0 for first generation |
| link_state | output | 2 | Synchronized link state |
| link_up | output | 1 | Link-up flag |

## Verification
The assertions take for granted that the strobes, address and write data are stable around the rising edge, and that the link state input is only sampled through the synchronizer, so its timing relative to the clock matters to the result but never to protocol legality. The stimulus drives every input on the falling edge, holds it for a full cycle, and mixes directed accesses to the two decoded offsets and to unmapped offsets with a long stretch of free-running accesses in which reads and writes may share a cycle and the link state changes at arbitrary cycles.

// File: rtl/hwcsr_pkg.sv
// Shared constants for the half-word write-masked register block.
// Assumes a 32-bit data path split into a mask half and a value half.
package hwcsr_pkg;
    localparam int unsigned CSR_W    = 32;
    localparam int unsigned HALF_W   = CSR_W / 2;
    localparam int unsigned LS_W     = 2;
    localparam int unsigned OFS_CTRL = 32'h00;
    localparam int unsigned OFS_STAT = 32'h48;
    localparam int unsigned CB_CFG   = 0;
    localparam int unsigned CB_TRAIN = 1;
    localparam int unsigned CB_RC    = 6;
    localparam int unsigned CB_GEN   = 7;
    localparam int unsigned SB_LS_LO = 20;
    localparam int unsigned SB_UP    = 0;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } csr_sel_e;
endpackage

// File: rtl/hwcsr_decode.sv
// Address decoder: maps a byte offset to a register select and qualifies
// the write strobe for the control register. Purely combinational.
module hwcsr_decode
    import hwcsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output csr_sel_e          sel,
    output logic              wr_ctrl
);
    // Select the register addressed by the current access.
    always_comb begin
        if (addr == ADDR_W'(OFS_CTRL))      sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
        else                                sel = SEL_NONE;
    end

    // Only the control register accepts writes.
    assign wr_ctrl = wr && (sel == SEL_CTRL);
endmodule

// File: rtl/hwcsr_mask_reg.sv
// Bit-masked control register: each bit updates only on a write whose
// mask bit is set. Assumes wr_hit is a one-cycle qualified strobe.
module hwcsr_mask_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        // Per-bit storage with its own write enable from the mask.
        always_ff @(posedge clk) begin
            if (!rst_n)                      bit_q <= 1'b0;
            else if (wr_hit && wr_mask[i])   bit_q <= wr_val[i];
        end
        assign q[i] = bit_q;
    end

    // Bits outside the mask keep their old values across a write.
    p_hold_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((q & ~$past(wr_mask)) == ($past(q) & ~$past(wr_mask))));
    // Masked bits take the written value.
    p_take_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((q & $past(wr_mask)) == ($past(wr_val) & $past(wr_mask))));
    // An all-zero mask changes nothing.
    p_zero_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (wr_mask == '0)) |=> $stable(q));
    // Without a write the register holds.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(q));
endmodule

// File: rtl/hwcsr_sync.sv
// Multi-flop synchronizer for a small asynchronous bus. Assumes the bus
// is a slowly changing level (state code), not a pulse. DEPTH >= 2.
module hwcsr_sync #(
    parameter int unsigned W     = 2,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [DEPTH-1:0][W-1:0] stage;

    // Shift the sampled input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[DEPTH-2:0], din};
    end

    assign dout = stage[DEPTH-1];

    // The last stage always follows the stage before it by one edge.
    p_sync_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage[DEPTH-1] == $past(stage[DEPTH-2])));
endmodule

// File: rtl/hwcsr_status.sv
// Status word builder: places the synchronized link state and the derived
// link-up flag into the read-only status layout.
module hwcsr_status
    import hwcsr_pkg::*;
(
    input  logic [LS_W-1:0]  link_state,
    output logic [CSR_W-1:0] status_word,
    output logic             link_up
);
    // Link is up only when every state bit is set.
    assign link_up = &link_state;

    // Assemble the status word; unused bits read as zero.
    always_comb begin
        status_word                         = '0;
        status_word[SB_LS_LO +: LS_W]       = link_state;
        status_word[SB_UP]                  = link_up;
    end
endmodule

// File: rtl/hwcsr_top.sv
// Half-word write-masked control and status register block.
// Assumes single-cycle read/write strobes with address and data valid in
// the same cycle; read data is registered one cycle after the strobe.
module hwcsr_top
    import hwcsr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic [LS_W-1:0]   link_state_async,
    output logic              cfg_enable,
    output logic              train_enable,
    output logic              rc_mode,
    output logic              gen_select,
    output logic [LS_W-1:0]   link_state,
    output logic              link_up
);
    csr_sel_e          sel;
    logic              wr_ctrl;
    logic [HALF_W-1:0] ctrl_q;
    logic [CSR_W-1:0]  status_word;
    logic [CSR_W-1:0]  rd_mux;
    logic [CSR_W-1:0]  rdata_q;

    hwcsr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .sel     (sel),
        .wr_ctrl (wr_ctrl)
    );

    hwcsr_mask_reg #(.W(HALF_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_ctrl),
        .wr_mask (bus_wdata[CSR_W-1:HALF_W]),
        .wr_val  (bus_wdata[HALF_W-1:0]),
        .q       (ctrl_q)
    );

    hwcsr_sync #(.W(LS_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (link_state_async),
        .dout  (link_state)
    );

    hwcsr_status u_stat (
        .link_state  (link_state),
        .status_word (status_word),
        .link_up     (link_up)
    );

    // Pick the read value for the addressed register.
    always_comb begin
        case (sel)
            SEL_CTRL: rd_mux = {{HALF_W{1'b0}}, ctrl_q};
            SEL_STAT: rd_mux = status_word;
            default:  rd_mux = '0;
        endcase
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata    = rdata_q;
    assign cfg_enable   = ctrl_q[CB_CFG];
    assign train_enable = ctrl_q[CB_TRAIN];
    assign rc_mode      = ctrl_q[CB_RC];
    assign gen_select   = ctrl_q[CB_GEN];

    // Read data only moves on a read strobe.
    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // Control reads carry nothing in the mask half.
    p_ctrl_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == ADDR_W'(OFS_CTRL))) |=> (bus_rdata[CSR_W-1:HALF_W] == '0));
    // Writes away from the control offset leave the outputs alone.
    p_other_wr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr != ADDR_W'(OFS_CTRL)))
        |=> $stable({cfg_enable, train_enable, rc_mode, gen_select}));
    // Link-up never shows with an incomplete link state.
    p_linkup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> (link_state == '1));
    // Unmapped reads return zero.
    p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr != ADDR_W'(OFS_CTRL)) && (bus_addr != ADDR_W'(OFS_STAT)))
        |=> (bus_rdata == '0));
endmodule

// File: tb/sim_hwcsr_top.sv
module sim_hwcsr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [1:0]  link_in = 2'b00;
    logic        cfg_enable, train_enable, rc_mode, gen_select, link_up;
    logic [1:0]  link_state;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    logic [15:0] m_ctrl = 16'h0;
    logic [31:0] m_rd = 32'h0;
    logic [1:0]  m_lsq[$];
    string       m_rtag = "R1";

    hwcsr_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .link_state_async(link_in), .cfg_enable(cfg_enable),
        .train_enable(train_enable), .rc_mode(rc_mode), .gen_select(gen_select),
        .link_state(link_state), .link_up(link_up)
    );

    always #4 clk = ~clk;

    function automatic logic [1:0] m_ls();
        return m_lsq[0];
    endfunction

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 16'h0;
            m_rd   = 32'h0;
            m_lsq  = {2'b00, 2'b00};
            m_rtag = "R1";
        end else begin
            if (bus_rd) begin
                if (bus_addr == 8'h00) begin
                    m_rd = {16'h0, m_ctrl}; m_rtag = "R5";
                end else if (bus_addr == 8'h48) begin
                    m_rd = 32'h0;
                    m_rd[21:20] = m_ls();
                    m_rd[0] = (m_ls() == 2'b11);
                    m_rtag = "R6";
                end else begin
                    m_rd = 32'h0; m_rtag = "R9";
                end
            end
            if (bus_wr && bus_addr == 8'h00)
                m_ctrl = (m_ctrl & ~bus_wdata[31:16]) | (bus_wdata[15:0] & bus_wdata[31:16]);
            m_lsq.push_back(link_in);
            void'(m_lsq.pop_front());
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model
    task automatic check_all();
        if (m_lsq.size() != 2) return;
        chk(cfg_enable == m_ctrl[0], "R4 cfg", {31'h0, cfg_enable}, {31'h0, m_ctrl[0]});
        chk(train_enable == m_ctrl[1], "R4 train", {31'h0, train_enable}, {31'h0, m_ctrl[1]});
        chk(rc_mode == m_ctrl[6], "R4 rc", {31'h0, rc_mode}, {31'h0, m_ctrl[6]});
        chk(gen_select == m_ctrl[7], "R4 gen", {31'h0, gen_select}, {31'h0, m_ctrl[7]});
        chk(link_state == m_ls(), "R8 state", {30'h0, link_state}, {30'h0, m_ls()});
        chk(link_up == (m_ls() == 2'b11), "R7 up", {31'h0, link_up}, {31'h0, m_ls() == 2'b11});
        chk(bus_rdata == m_rd, m_rtag, bus_rdata, m_rd);
    endtask

    task automatic drive(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (!done) check_all();
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle();
        drive(0, 0, 8'h00, 32'h0);
    endtask

    task automatic write_read_ctrl(input logic [31:0] d, input logic [15:0] exp, input string tag);
        drive(1, 0, 8'h00, d);
        drive(0, 1, 8'h00, 32'h0);
        idle();
        chk(bus_rdata == {16'h0, exp}, tag, bus_rdata, {16'h0, exp});
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({bus_rdata, cfg_enable, train_enable, rc_mode, gen_select, link_up} == 37'h0,
            "R1", {27'h0, cfg_enable, train_enable, rc_mode, gen_select, link_up}, 32'h0);
        rst_n = 1'b1;
        idle();

        // R2: masked write touches only masked bits
        write_read_ctrl(32'h00C3_00C1, 16'h00C1, "R2");
        chk({cfg_enable, train_enable, rc_mode, gen_select} == 4'b1011, "R4",
            {28'h0, cfg_enable, train_enable, rc_mode, gen_select}, 32'hB);
        write_read_ctrl(32'h0002_FFFF, 16'h00C3, "R2");
        // R3: zero mask leaves register unchanged
        write_read_ctrl(32'h0000_FFFF, 16'h00C3, "R3");
        // R4: clearing generation select picks first generation
        write_read_ctrl(32'h0080_0000, 16'h0043, "R4");
        chk(gen_select == 1'b0, "R4 gen1", {31'h0, gen_select}, 32'h0);
        // R5: full 16-bit value, upper half reads 0
        write_read_ctrl(32'hFFFF_A5A5, 16'hA5A5, "R5");
        write_read_ctrl(32'hFF00_0000, 16'h00A5, "R2");
        // R6: write to status offset ignored
        write_read_ctrl(32'h0000_0000, 16'h00A5, "R3");
        drive(1, 0, 8'h48, 32'hFFFF_0000);
        drive(0, 1, 8'h00, 32'h0);
        idle();
        chk(bus_rdata == 32'h0000_00A5, "R6 wr", bus_rdata, 32'h0000_00A5);
        // R9: unmapped write ignored, unmapped read zero
        drive(1, 0, 8'h10, 32'hFFFF_0000);
        drive(0, 1, 8'h00, 32'h0);
        idle();
        chk(bus_rdata == 32'h0000_00A5, "R9 wr", bus_rdata, 32'h0000_00A5);
        drive(0, 1, 8'h10, 32'h0);
        idle();
        chk(bus_rdata == 32'h0, "R9 rd", bus_rdata, 32'h0);

        // R8: two-edge synchronizer latency; R7: link-up decode
        link_in = 2'b11;
        idle();
        chk(link_state == 2'b00, "R8 one edge", {30'h0, link_state}, 32'h0);
        idle();
        chk(link_state == 2'b11, "R8 two edges", {30'h0, link_state}, 32'h3);
        chk(link_up == 1'b1, "R7 up", {31'h0, link_up}, 32'h1);
        drive(0, 1, 8'h48, 32'h0);
        idle();
        chk(bus_rdata == 32'h0030_0001, "R6 rd up", bus_rdata, 32'h0030_0001);
        link_in = 2'b10;
        idle(); idle();
        chk(link_up == 1'b0, "R7 partial", {31'h0, link_up}, 32'h0);
        drive(0, 1, 8'h48, 32'h0);
        idle();
        chk(bus_rdata == 32'h0020_0000, "R6 rd partial", bus_rdata, 32'h0020_0000);
        link_in = 2'b01;
        idle(); idle();
        chk(link_up == 1'b0, "R7 low only", {31'h0, link_up}, 32'h0);

        // Free-running mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            case ($urandom_range(3))
                0, 1: a = 8'h00;
                2:    a = 8'h48;
                default: a = 8'($urandom_range(255));
            endcase
            if ($urandom_range(7) == 0) link_in = 2'($urandom_range(3));
            drive(1'($urandom_range(1)), 1'($urandom_range(1)), a, $urandom());
        end
        idle(); idle();

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule